// File: doc/BRIEF.md
# Maximal-Length Pseudo-Random Sequence Generator

This block produces a pseudo-random bit stream and the matching state word from a linear feedback shift register. The register width is fixed at elaboration. The feedback taps for that width come from a built-in table of tap sets, each of which gives the longest possible sequence. A second parameter selects the feedback arrangement. In the many-to-one form, the XOR of all tapped bits feeds a single end stage. In the one-to-many form, the outgoing top bit is XORed into several stages as the register shifts, so no stage sits behind more than one gate.

The register advances one step on each rising clock edge while the step enable is high, and holds its value otherwise. A synchronous, active-high reset loads all ones, so the register can never start in the dead all-zero state, from which XOR feedback could never escape. A flag reports that dead state if it ever appears.

The width parameter accepts 3 to 16. Any other value stops elaboration with an error.

Top module: `lfsr_gen`

## Requirements
- R1: When `rst` is high at a rising edge, every state bit is 1 after that edge, whatever `stepEn` is. `stuckFlag` is low.
- R2: With `rst` low and `stepEn` low at an edge, `stateWord` keeps its value.
- R3: With `rst` low and `stepEn` high, the state advances exactly one step per rising edge.
- R4: Many-to-one (TOPOLOGY = TOPO_MANY_TO_ONE, encoding 0): bit i takes old bit i-1 for i ≥ 1, and bit 0 takes the XOR of the old bits at the tap positions.
- R5: One-to-many (TOPOLOGY = TOPO_ONE_TO_MANY, encoding 1): bit 0 takes the old top bit. For i ≥ 1, bit i takes old bit i-1, XORed with the old top bit when position i-1 is a tap below the top bit.
- R6: The tap positions (bit indices) are: width 3 {0,2}, 4 {0,3}, 5 {1,4}, 6 {0,5}, 7 {0,6}, 8 {1,2,3,7}, 9 {3,8}, 10 {2,9}, 11 {1,10}, 12 {0,3,5,11}, 13 {0,2,3,12}, 14 {0,2,4,13}, 15 {0,14}, 16 {1,2,4,15}.
- R7: After reset, with `stepEn` held high, the state first returns to all ones after exactly 2^n − 1 steps. This holds for every width from 3 to 16 in both topologies.
- R8: `serialOut` always equals the top state bit, `stateWord[WIDTH-1]`.
- R9: `stuckFlag` is high exactly when the state is all zeros. From reset, the state never reaches all zeros, so the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads all ones |
| stepEn | input | 1 | Advance one step at the next edge when high |
| serialOut | output | 1 | Pseudo-random bit (top state bit) |
| stateWord | output | WIDTH | Full register state |
| stuckFlag | output | 1 | High while the state is all zeros |

## Verification
Each state change caused by `rst` or `stepEn` appears one edge later. Inputs are driven on the falling edge, and the result is sampled at the next falling edge, after exactly one rising edge. `serialOut` and `stuckFlag` follow the state with no added register, so they are checked in the same sample as the state. The period test leaves the enable high and counts falling edges from the release of reset. After k steps the state sampled is the k-th successor, so the first count at which the state is all ones is the period.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // Feedback arrangement selector
  typedef enum logic {
    TOPO_MANY_TO_ONE = 1'b0,
    TOPO_ONE_TO_MANY = 1'b1
  } topo_e;

  localparam int MIN_WIDTH = 3;
  localparam int MAX_WIDTH = 16;
  localparam int MASK_BITS = MAX_WIDTH;

  // Control-to-datapath strobes
  typedef struct packed {
    logic seed;     // load all ones
    logic advance;  // take one step
  } lfsr_strobe_t;

  // Maximal-length tap positions, one bit per tapped index
  function automatic logic [MASK_BITS-1:0] tapSet(input int width);
    logic [MASK_BITS-1:0] m;
    case (width)
      3:       m = 16'h0005;
      4:       m = 16'h0009;
      5:       m = 16'h0012;
      6:       m = 16'h0021;
      7:       m = 16'h0041;
      8:       m = 16'h008E;
      9:       m = 16'h0108;
      10:      m = 16'h0204;
      11:      m = 16'h0402;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      14:      m = 16'h2015;
      15:      m = 16'h4001;
      16:      m = 16'h8016;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lfsr_control.sv
module lfsr_control #(
  parameter int WIDTH = 8
) (
  input  logic                     rst,
  input  logic                     stepEn,
  input  logic [WIDTH-1:0]         stateQ,
  output lfsr_pkg::lfsr_strobe_t   strobes,
  output logic                     stuckFlag
);

  // Reset has priority over stepping
  always_comb begin
    strobes.seed    = rst;
    strobes.advance = stepEn & ~rst;
  end

  // Dead-state detect
  assign stuckFlag = ~|stateQ;

endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath #(
  parameter int              WIDTH    = 8,
  parameter lfsr_pkg::topo_e TOPOLOGY = lfsr_pkg::TOPO_MANY_TO_ONE
) (
  input  logic                   clk,
  input  lfsr_pkg::lfsr_strobe_t strobes,
  output logic [WIDTH-1:0]       stateQ
);

  localparam logic [lfsr_pkg::MASK_BITS-1:0] TAP_FULL = lfsr_pkg::tapSet(WIDTH);
  localparam logic [WIDTH-1:0] TAP_MASK    = TAP_FULL[WIDTH-1:0];
  // Injection points for the one-to-many form: tap t feeds stage t+1
  localparam logic [WIDTH-1:0] INJECT_MASK = {TAP_FULL[WIDTH-2:0], 1'b0};

  logic [WIDTH-1:0] stateNext;

  generate
    if (TOPOLOGY == lfsr_pkg::TOPO_MANY_TO_ONE) begin : g_many
      logic feedBit;
      assign feedBit   = ^(stateQ & TAP_MASK);
      assign stateNext = {stateQ[WIDTH-2:0], feedBit};
    end else begin : g_one
      logic topBit;
      assign topBit       = stateQ[WIDTH-1];
      assign stateNext[0] = topBit;
      for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        if (INJECT_MASK[i]) begin : g_xor
          assign stateNext[i] = stateQ[i-1] ^ topBit;
        end else begin : g_pass
          assign stateNext[i] = stateQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.seed)         stateQ <= '1;
    else if (strobes.advance) stateQ <= stateNext;
  end

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int              WIDTH    = 8,
  parameter lfsr_pkg::topo_e TOPOLOGY = lfsr_pkg::TOPO_MANY_TO_ONE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  output logic             serialOut,
  output logic [WIDTH-1:0] stateWord,
  output logic             stuckFlag
);

  generate
    if (WIDTH < lfsr_pkg::MIN_WIDTH || WIDTH > lfsr_pkg::MAX_WIDTH) begin : g_badWidth
      $error("lfsr_gen: WIDTH must lie in 3..16");
    end
  endgenerate

  lfsr_pkg::lfsr_strobe_t strobes;
  logic [WIDTH-1:0]       stateQ;

  lfsr_control #(.WIDTH(WIDTH)) u_ctrl (
    .rst       (rst),
    .stepEn    (stepEn),
    .stateQ    (stateQ),
    .strobes   (strobes),
    .stuckFlag (stuckFlag)
  );

  lfsr_datapath #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  assign stateWord = stateQ;
  assign serialOut = stateQ[WIDTH-1];

endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stepEn,
  input logic [WIDTH-1:0] stateWord,
  input logic             stuckFlag
);

  logic started = 1'b0;
  always_ff @(posedge clk) if (rst) started <= 1'b1;

  AST_SEED_ONES: assert property (@(posedge clk)
    rst |=> (stateWord == '1) && !stuckFlag); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst || !started)
    !stepEn |=> $stable(stateWord)); // R2

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst || !started)
    stepEn |=> stateWord != $past(stateWord)); // R3

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst || !started)
    (stateWord != '0) && !stuckFlag); // R9

endmodule

bind lfsr_gen lfsr_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stepEn    (stepEn),
  .stateWord (stateWord),
  .stuckFlag (stuckFlag)
);

// File: tb/sim_lfsr_gen.sv
`timescale 1ns/1ps
module sim_lfsr_gen;

  localparam int BW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic stepEn = 1'b0;
  logic gridRst = 1'b1;
  logic gridEn = 1'b0;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  // Main units: many-to-one (u0) and one-to-many (u1), width 8
  logic          serA, stuckA, serB, stuckB;
  logic [BW-1:0] stA, stB;

  lfsr_gen #(.WIDTH(BW), .TOPOLOGY(lfsr_pkg::TOPO_MANY_TO_ONE)) u0 (
    .clk(clk), .rst(rst), .stepEn(stepEn),
    .serialOut(serA), .stateWord(stA), .stuckFlag(stuckA));

  lfsr_gen #(.WIDTH(BW), .TOPOLOGY(lfsr_pkg::TOPO_ONE_TO_MANY)) u1 (
    .clk(clk), .rst(rst), .stepEn(stepEn),
    .serialOut(serB), .stateWord(stB), .stuckFlag(stuckB));

  // Grid of every width and both topologies, for the period check
  logic [15:0] gridState [2][14];
  logic        gridStuck [2][14];

  for (genvar t = 0; t < 2; t++) begin : g_topo
    for (genvar w = 3; w <= 16; w++) begin : g_w
      logic [w-1:0] sw;
      logic         so, sf;
      lfsr_gen #(.WIDTH(w), .TOPOLOGY(lfsr_pkg::topo_e'(t))) u_g (
        .clk(clk), .rst(gridRst), .stepEn(gridEn),
        .serialOut(so), .stateWord(sw), .stuckFlag(sf));
      assign gridState[t][w-3] = 16'(sw);
      assign gridStuck[t][w-3] = sf;
    end
  end

  // Tap table from the requirements, written as index lists
  function automatic logic [15:0] benchTaps(input int w);
    case (w)
      3:  return (16'd1 << 0) | (16'd1 << 2);
      4:  return (16'd1 << 0) | (16'd1 << 3);
      5:  return (16'd1 << 1) | (16'd1 << 4);
      6:  return (16'd1 << 0) | (16'd1 << 5);
      7:  return (16'd1 << 0) | (16'd1 << 6);
      8:  return (16'd1 << 1) | (16'd1 << 2) | (16'd1 << 3) | (16'd1 << 7);
      9:  return (16'd1 << 3) | (16'd1 << 8);
      10: return (16'd1 << 2) | (16'd1 << 9);
      11: return (16'd1 << 1) | (16'd1 << 10);
      12: return (16'd1 << 0) | (16'd1 << 3) | (16'd1 << 5) | (16'd1 << 11);
      13: return (16'd1 << 0) | (16'd1 << 2) | (16'd1 << 3) | (16'd1 << 12);
      14: return (16'd1 << 0) | (16'd1 << 2) | (16'd1 << 4) | (16'd1 << 13);
      15: return (16'd1 << 0) | (16'd1 << 14);
      16: return (16'd1 << 1) | (16'd1 << 2) | (16'd1 << 4) | (16'd1 << 15);
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] allOnes(input int w);
    return 16'((32'd1 << w) - 1);
  endfunction

  // R4 model
  function automatic logic [15:0] manyNext(input logic [15:0] s, input int w);
    logic fb;
    fb = ^(s & benchTaps(w));
    return ((s << 1) | 16'(fb)) & allOnes(w);
  endfunction

  // R5 model
  function automatic logic [15:0] oneNext(input logic [15:0] s, input int w);
    logic [15:0] n;
    n = (s << 1) & allOnes(w);
    if (s[w-1]) n = n ^ (((benchTaps(w) << 1) & allOnes(w)) | 16'd1);
    return n;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vecCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  logic [15:0] expA, expB;

  // Drive at falling edge, sample at the next falling edge
  task automatic stepAndCheck(input logic r, input logic e, input string tag);
    rst = r;
    stepEn = e;
    @(negedge clk);
    if (r) begin
      expA = allOnes(BW);
      expB = allOnes(BW);
    end else if (e) begin
      expA = manyNext(expA, BW);
      expB = oneNext(expB, BW);
    end
    check({tag, " u0 state"}, 16'(stA), expA);
    check({tag, " u1 state"}, 16'(stB), expB);
    check("R8 u0 serial", 16'(serA), 16'(expA[BW-1]));
    check("R8 u1 serial", 16'(serB), 16'(expB[BW-1]));
    check("R9 u0 flag", 16'(stuckA), 16'(expA == 16'd0));
    check("R9 u1 flag", 16'(stuckB), 16'(expB == 16'd0));
  endtask

  int firstRet [2][14];
  logic sawZero [2][14];

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    // R1: reset state
    stepAndCheck(1'b1, 1'b0, "R1 reset");
    stepAndCheck(1'b1, 1'b1, "R1 reset over step");
    // R2: hold with enable low
    for (int i = 0; i < 5; i++) stepAndCheck(1'b0, 1'b0, "R2 hold");
    // R3 R4 R5 R6: continuous steps from all ones
    for (int i = 0; i < 300; i++) stepAndCheck(1'b0, 1'b1, "R3 R4 R5 R6 run");
    // R2 after movement
    for (int i = 0; i < 4; i++) stepAndCheck(1'b0, 1'b0, "R2 hold mid");
    // Mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic r, e;
      r = ($urandom % 97) == 0;
      e = ($urandom % 4) != 0;
      stepAndCheck(r, e, "R1 R2 R3 R4 R5 random");
    end
    // R1 reset in the middle of a run
    stepAndCheck(1'b1, 1'b1, "R1 mid reset");
    stepAndCheck(1'b0, 1'b1, "R3 first step");

    // R6 R7: period for every width and topology
    @(negedge clk);
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < 14; k++) begin
        firstRet[t][k] = 0;
        sawZero[t][k] = 1'b0;
        check("R1 grid reset", gridState[t][k], allOnes(k + 3));
      end
    gridRst = 1'b0;
    gridEn = 1'b1;
    for (int c = 1; c <= 65536; c++) begin
      @(negedge clk);
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 14; k++) begin
          if (gridState[t][k] == 16'd0 || gridStuck[t][k]) sawZero[t][k] = 1'b1;
          if (firstRet[t][k] == 0 && gridState[t][k] == allOnes(k + 3))
            firstRet[t][k] = c;
        end
    end
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < 14; k++) begin
        check($sformatf("R6 R7 period w%0d topo%0d", k + 3, t),
              16'(firstRet[t][k]), 16'((32'd1 << (k + 3)) - 1));
        check($sformatf("R9 no lockup w%0d topo%0d", k + 3, t),
              16'(sawZero[t][k]), 16'd0);
      end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule